// File: doc/BRIEF.md
# Pin Interrupt Detector Bank

This block watches a bank of general-purpose input pins and turns selected pin activity into interrupt requests. Every pin passes through a two-stage input conditioner whose stages can each be bypassed, clocked on the rising edge or clocked on the falling edge. The conditioned value then feeds a trigger detector. Each pin's detector responds to a rising edge, a falling edge, either edge, a low level or a high level, or it can be switched off.

Detected events are latched into one shared status word. Software manages that word through a plain read/write address and two alias addresses, one that sets bits and one that clears them. Per-pin enable bits route the latched status to two summary outputs, one for a maskable interrupt and one for a non-maskable interrupt. A separate per-pin enable lets an active trigger condition raise a wakeup request directly. A read-only view shows the unlatched trigger condition of every pin in the current cycle.

Registers are reached over a simple single-cycle port. A write takes effect at the next rising clock edge. Read data is combinational from the address.

Top module: `gpio_irq_unit`

## Requirements
- R1: The 3-bit trigger code in per-pin word bits [9:7] selects the condition. Code 1 fires on a rising edge, 2 on a falling edge and 3 on either edge. Codes 0, 6 and 7 never fire.
- R2: Code 5 fires on every cycle that the conditioned input is high, and code 4 on every cycle that it is low. A status bit that is cleared while the level persists is set again on the following edge.
- R3: A write to address 0x44 replaces the status word with the written data. A read of 0x44 returns the status word.
- R4: Writing ones to address 0x48 sets those status bits, and writing ones to 0x4C clears them. Zero bits written to either alias leave status unchanged. Both aliases read as 0.
- R5: A trigger event and a software write that would clear the same status bit in the same cycle leave that bit set.
- R6: Address 0x5C reads status AND the per-pin bit 13 enables, and address 0x60 reads status AND the per-pin bit 14 enables. irq_o is the OR of the first of these, and nmi_o is the OR of the second.
- R7: Address 0x14C reads, for each pin, whether its trigger condition holds in the current cycle, before latching.
- R8: wake_o is high in any cycle where a pin with per-pin bit 10 set meets its trigger condition.
- R9: After reset, all configuration, status and summary values and all outputs are 0.
- R10: The first conditioner stage uses per-pin bits [4:3] and the second uses bits [1:0]. Each stage field selects: 0 passes the input through, 1 samples it on the falling clock edge, and 2 or 3 samples it on the rising clock edge.
- R11: Pin n's word is at 0x74 + 4n. It reads back only bits 0, 1, 3, 4, 7, 8, 9, 10, 13 and 14, and all other bits read 0. Unmapped addresses read 0, and writes to them have no effect.
- R12: Edge codes compare the conditioned input with its value one rising clock edge earlier. An input held steady yields no further edge events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw pin levels |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_we_i | input | 1 | Write strobe, applied at the next rising edge |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| irq_o | output | 1 | Maskable interrupt summary |
| nmi_o | output | 1 | Non-maskable interrupt summary |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench keeps a behavioural model of every pin, and that model includes the falling-edge samplers. A design that routes a conditioner stage to the wrong clock edge shows its events half a cycle early or late. Under a level trigger, a software clear that collides with a live level must leave the bit set. A design that lets software win here drops an interrupt for one cycle, and the per-cycle status read reveals it. The bench drives the unusable trigger codes 6 and 7 and watches for spurious events. It also writes all-ones to the configuration words and checks the readback, so an unimplemented bit that reads back as 1 is caught. Alias writes carrying mixed zero and one bits show whether zeros are wrongly acted on.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_STATUS   = 'h044;
  localparam int unsigned ADDR_SET      = 'h048;
  localparam int unsigned ADDR_CLR      = 'h04C;
  localparam int unsigned ADDR_SUM_IRQ  = 'h05C;
  localparam int unsigned ADDR_SUM_NMI  = 'h060;
  localparam int unsigned ADDR_PIN_BASE = 'h074;
  localparam int unsigned PIN_STRIDE    = 4;
  localparam int unsigned ADDR_EVT_SRC  = 'h14C;

  // bit positions inside a per-pin word
  localparam int unsigned B_SYNC_B = 0;
  localparam int unsigned B_SYNC_A = 3;
  localparam int unsigned B_TRIG   = 7;
  localparam int unsigned B_WAKE   = 10;
  localparam int unsigned B_IRQ    = 13;
  localparam int unsigned B_NMI    = 14;
  localparam int unsigned WORD_W   = 15;

  typedef enum logic [2:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;

  typedef enum logic [1:0] {
    SMP_THRU = 2'd0,
    SMP_NEG  = 2'd1
  } smp_e;

  typedef struct packed {
    logic       nmi_en;
    logic       irq_en;
    logic       wake_en;
    logic [2:0] trig;
    logic [1:0] sync_a;
    logic [1:0] sync_b;
  } pin_cfg_t;

  function automatic pin_cfg_t word_to_cfg(logic [WORD_W-1:0] w);
    pin_cfg_t c;
    c.nmi_en  = w[B_NMI];
    c.irq_en  = w[B_IRQ];
    c.wake_en = w[B_WAKE];
    c.trig    = w[B_TRIG+:3];
    c.sync_a  = w[B_SYNC_A+:2];
    c.sync_b  = w[B_SYNC_B+:2];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(pin_cfg_t c);
    logic [WORD_W-1:0] w;
    w               = '0;
    w[B_NMI]        = c.nmi_en;
    w[B_IRQ]        = c.irq_en;
    w[B_WAKE]       = c.wake_en;
    w[B_TRIG+:3]    = c.trig;
    w[B_SYNC_A+:2]  = c.sync_a;
    w[B_SYNC_B+:2]  = c.sync_b;
    return w;
  endfunction

endpackage

// File: rtl/gpio_sync_stage.sv
module gpio_sync_stage
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       d_i,
  output logic       q_o
);

  logic pos_q, neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= 1'b0;
    else         pos_q <= d_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= d_i;
  end

  always_comb begin
    if (mode_i == SMP_THRU)     q_o = d_i;
    else if (mode_i == SMP_NEG) q_o = neg_q;
    else                        q_o = pos_q;
  end

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] trig_i,
  input  logic       d_i,
  output logic       hit_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  always_comb begin
    unique case (trig_i)
      TRIG_RISE: hit_o = d_i & ~prev_q;
      TRIG_FALL: hit_o = ~d_i & prev_q;
      TRIG_BOTH: hit_o = d_i ^ prev_q;
      TRIG_LOW:  hit_o = ~d_i;
      TRIG_HIGH: hit_o = d_i;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       we_i,
  input  logic [NUM_PINS-1:0]        hit_i,
  output pin_cfg_t [NUM_PINS-1:0]    cfg_o,
  output logic [NUM_PINS-1:0]        status_o,
  output logic [NUM_PINS-1:0]        sum_irq_o,
  output logic [NUM_PINS-1:0]        sum_nmi_o,
  output logic [DATA_W-1:0]          rdata_o
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(ADDR_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(ADDR_CLR);
  localparam logic [ADDR_W-1:0] A_SUMI   = ADDR_W'(ADDR_SUM_IRQ);
  localparam logic [ADDR_W-1:0] A_SUMN   = ADDR_W'(ADDR_SUM_NMI);
  localparam logic [ADDR_W-1:0] A_EVT    = ADDR_W'(ADDR_EVT_SRC);

  logic [NUM_PINS-1:0] status_q, status_d, sw_val, wbits;
  logic [NUM_PINS-1:0] pin_sel;
  logic                unused_wdata;

  assign wbits        = wdata_i[NUM_PINS-1:0];
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
    assign pin_sel[i] = (addr_i == ADDR_W'(ADDR_PIN_BASE + PIN_STRIDE * i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cfg_o[i] <= '0;
      else if (we_i && pin_sel[i]) cfg_o[i] <= word_to_cfg(wdata_i[WORD_W-1:0]);
    end

    assign sum_irq_o[i] = status_q[i] & cfg_o[i].irq_en;
    assign sum_nmi_o[i] = status_q[i] & cfg_o[i].nmi_en;
  end

  // software result first, trigger events ORed last so they win a collision
  always_comb begin
    sw_val = status_q;
    if (we_i) begin
      if (addr_i == A_STATUS)   sw_val = wbits;
      else if (addr_i == A_SET) sw_val = status_q | wbits;
      else if (addr_i == A_CLR) sw_val = status_q & ~wbits;
    end
    status_d = sw_val | hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_STATUS)    rdata_o[NUM_PINS-1:0] = status_q;
    else if (addr_i == A_SUMI) rdata_o[NUM_PINS-1:0] = sum_irq_o;
    else if (addr_i == A_SUMN) rdata_o[NUM_PINS-1:0] = sum_nmi_o;
    else if (addr_i == A_EVT)  rdata_o[NUM_PINS-1:0] = hit_i;
    else begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (pin_sel[i]) rdata_o[WORD_W-1:0] = cfg_to_word(cfg_o[i]);
      end
    end
  end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic                reg_we_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                irq_o,
  output logic                nmi_o,
  output logic                wake_o
);

  pin_cfg_t [NUM_PINS-1:0] cfg_w;
  logic [NUM_PINS-1:0]     stg_a_w, stg_b_w, hit_w, status_w;
  logic [NUM_PINS-1:0]     sum_irq_w, sum_nmi_w, wake_vec_w;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_sync_stage u_stg_a (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(cfg_w[i].sync_a),
      .d_i   (pin_i[i]),
      .q_o   (stg_a_w[i])
    );

    gpio_sync_stage u_stg_b (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(cfg_w[i].sync_b),
      .d_i   (stg_a_w[i]),
      .q_o   (stg_b_w[i])
    );

    gpio_trig_detect u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .trig_i(cfg_w[i].trig),
      .d_i   (stg_b_w[i]),
      .hit_o (hit_w[i])
    );

    assign wake_vec_w[i] = hit_w[i] & cfg_w[i].wake_en;
  end

  gpio_irq_regs #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .we_i     (reg_we_i),
    .hit_i    (hit_w),
    .cfg_o    (cfg_w),
    .status_o (status_w),
    .sum_irq_o(sum_irq_w),
    .sum_nmi_o(sum_nmi_w),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o  = |sum_irq_w;
  assign nmi_o  = |sum_nmi_w;
  assign wake_o = |wake_vec_w;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [NUM_PINS-1:0]     hit_i,
  input logic [NUM_PINS-1:0]     status_i,
  input pin_cfg_t [NUM_PINS-1:0] cfg_i,
  input logic                    irq_o,
  input logic                    nmi_o,
  input logic                    wake_o
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_i[i].trig == 3'd0 || cfg_i[i].trig > 3'd5) |-> !hit_i[i]);
  end

  a_r5_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((status_i & $past(hit_i)) == $past(hit_i)));

  a_r4_status_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && hit_i == '0) |=> $stable(status_i));

  a_r6_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0));

  a_r6_nmi_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (status_i != '0));

  a_r8_wake_has_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (hit_i != '0));

endmodule

bind gpio_irq_unit gpio_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .hit_i   (hit_w),
  .status_i(status_w),
  .cfg_i   (cfg_w),
  .irq_o   (irq_o),
  .nmi_o   (nmi_o),
  .wake_o  (wake_o)
);

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;
  localparam int NP = 8;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam bit [31:0] CFG_MASK = 32'h0000_679B;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [AW-1:0] reg_addr_i = 12'h044;
  logic [DW-1:0] reg_wdata_i = '0;
  logic          reg_we_i = 1'b0;
  logic [DW-1:0] reg_rdata_o;
  logic          irq_o, nmi_o, wake_o;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  string phase = "R9 reset";

  always #2 clk_i = ~clk_i;

  gpio_irq_unit #(.NUM_PINS(NP), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_we_i(reg_we_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .nmi_o(nmi_o), .wake_o(wake_o)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_cfg [NP];
  bit        m_pos1 [NP], m_neg1 [NP], m_pos2 [NP], m_neg2 [NP], m_prev [NP];
  bit [NP-1:0] m_st;

  function automatic bit pick(bit [1:0] m, bit d, bit n, bit p);
    if (m == 2'd0) return d;
    if (m == 2'd1) return n;
    return p;
  endfunction

  function automatic bit s1v(int i);
    return pick(m_cfg[i][4:3], pin_i[i], m_neg1[i], m_pos1[i]);
  endfunction

  function automatic bit s2v(int i);
    return pick(m_cfg[i][1:0], s1v(i), m_neg2[i], m_pos2[i]);
  endfunction

  function automatic bit condv(int i);
    bit s, p;
    s = s2v(i);
    p = m_prev[i];
    case (m_cfg[i][9:7])
      3'd1: return s & !p;
      3'd2: return !s & p;
      3'd3: return s ^ p;
      3'd4: return !s;
      3'd5: return s;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [NP-1:0] cond_vec();
    bit [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = condv(i);
    return v;
  endfunction

  function automatic bit [NP-1:0] en_vec(int b);
    bit [NP-1:0] v;
    for (int i = 0; i < NP; i++) v[i] = m_cfg[i][b];
    return v;
  endfunction

  function automatic bit [31:0] exp_rd(int a);
    if (a == 'h044) return 32'(m_st);
    if (a == 'h05C) return 32'(m_st & en_vec(13));
    if (a == 'h060) return 32'(m_st & en_vec(14));
    if (a == 'h14C) return 32'(cond_vec());
    for (int i = 0; i < NP; i++) if (a == 'h074 + 4 * i) return m_cfg[i];
    return 32'd0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = '0;
      for (int i = 0; i < NP; i++) begin
        m_cfg[i] = '0; m_pos1[i] = 0; m_neg1[i] = 0;
        m_pos2[i] = 0; m_neg2[i] = 0; m_prev[i] = 0;
      end
    end else begin
      bit [NP-1:0] c, nst;
      bit o1 [NP];
      bit o2 [NP];
      int a;
      a = int'(reg_addr_i);
      c = cond_vec();
      for (int i = 0; i < NP; i++) begin o1[i] = s1v(i); o2[i] = s2v(i); end
      nst = m_st;
      if (reg_we_i) begin
        if (a == 'h044) nst = reg_wdata_i[NP-1:0];
        else if (a == 'h048) nst = m_st | reg_wdata_i[NP-1:0];
        else if (a == 'h04C) nst = m_st & ~reg_wdata_i[NP-1:0];
        for (int i = 0; i < NP; i++)
          if (a == 'h074 + 4 * i) m_cfg[i] = reg_wdata_i & CFG_MASK;
      end
      m_st = nst | c;
      for (int i = 0; i < NP; i++) begin
        m_pos1[i] = pin_i[i]; m_pos2[i] = o1[i]; m_prev[i] = o2[i];
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit o1 [NP];
      for (int i = 0; i < NP; i++) o1[i] = s1v(i);
      for (int i = 0; i < NP; i++) begin m_neg1[i] = pin_i[i]; m_neg2[i] = o1[i]; end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s [%s] t=%0t act=%h exp=%h", tag, phase, $time, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #3;
    if (rst_ni && !done) begin
      chk("R3/R6/R7/R11 rdata", reg_rdata_o, exp_rd(int'(reg_addr_i)));
      chk("R6 irq_o", 32'(irq_o), 32'(|(m_st & en_vec(13))));
      chk("R6 nmi_o", 32'(nmi_o), 32'(|(m_st & en_vec(14))));
      chk("R8 wake_o", 32'(wake_o), 32'(|(cond_vec() & en_vec(10))));
    end
  end

  task automatic wr(int a, bit [31:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = AW'(a); reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; reg_addr_i = 12'h044;
  endtask

  task automatic look(int a, int n);
    @(posedge clk_i); #1;
    reg_addr_i = AW'(a);
    repeat (n) @(posedge clk_i);
    #1 reg_addr_i = 12'h044;
  endtask

  task automatic pins(bit [NP-1:0] v, int hold);
    @(posedge clk_i); #1;
    pin_i = v;
    repeat (hold) @(posedge clk_i);
  endtask

  function automatic bit [31:0] pw(bit [1:0] sa, bit [1:0] sb, bit [2:0] tr,
                                   bit wk, bit ie, bit ne);
    return (32'(ne) << 14) | (32'(ie) << 13) | (32'(wk) << 10) |
           (32'(tr) << 7) | (32'(sa) << 3) | 32'(sb);
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #3;
    phase = "R9 reset";
    chk("R9 status", reg_rdata_o, 32'd0);
    chk("R9 irq/nmi/wake", {29'd0, irq_o, nmi_o, wake_o}, 32'd0);
    look('h074, 1); look('h05C, 1); look('h060, 1); look('h14C, 1);

    phase = "R11 cfg readback";
    wr('h074, 32'hFFFF_FFFF);
    look('h074, 2);
    wr('h200, 32'hFFFF_FFFF);
    look('h200, 1); look('h078, 1);
    wr('h074, 0);
    wr('h044, 0);

    phase = "R1 edge codes";
    wr('h074, pw(0, 0, 1, 0, 0, 0));
    wr('h078, pw(0, 0, 2, 0, 0, 0));
    wr('h07C, pw(0, 0, 3, 0, 0, 0));
    wr('h080, pw(0, 0, 6, 0, 0, 0));
    wr('h084, pw(0, 0, 7, 0, 0, 0));
    pins(8'h1F, 3);
    look('h14C, 1);
    wr('h044, 0);
    phase = "R12 steady input";
    pins(8'h1F, 4);
    phase = "R1 falling";
    pins(8'h00, 3);
    wr('h044, 0);

    phase = "R2 level codes";
    wr('h088, pw(0, 0, 5, 0, 0, 0));
    wr('h08C, pw(0, 0, 4, 0, 0, 0));
    pins(8'h10, 3);
    wr('h04C, 32'h30);
    pins(8'h10, 3);
    phase = "R5 clear vs event";
    wr('h04C, 32'hFF);
    wr('h044, 32'h00);
    pins(8'h30, 2);
    wr('h088, 0); wr('h08C, 0);
    wr('h044, 0);

    phase = "R3 direct write";
    wr('h044, 32'hFFFF_FFA5);
    phase = "R4 set/clear aliases";
    wr('h048, 32'h0000_000A);
    look('h048, 1); look('h04C, 1);
    wr('h04C, 32'h0000_0021);
    wr('h048, 32'h0000_0000);
    wr('h04C, 32'h0000_0000);

    phase = "R6 summaries";
    wr('h074, pw(0, 0, 0, 0, 1, 0));
    wr('h078, pw(0, 0, 0, 0, 0, 1));
    wr('h044, 0);
    look('h05C, 1); look('h060, 1);
    wr('h048, 32'h1); look('h05C, 2);
    wr('h048, 32'h2); look('h060, 2);
    wr('h04C, 32'h1); look('h060, 1);
    wr('h044, 0);

    phase = "R8 R7 wakeup";
    wr('h07C, pw(0, 0, 3, 1, 0, 0));
    @(posedge clk_i); #1 reg_addr_i = 12'h14C;
    pins(8'h04, 2); pins(8'h00, 2);
    wr('h07C, pw(0, 0, 3, 0, 0, 0));
    pins(8'h04, 2);
    wr('h044, 0);

    phase = "R10 conditioner modes";
    for (int k = 0; k < 16; k++) begin
      wr('h090, pw(2'(k >> 2), 2'(k), 3, 0, 1, 0));
      wr('h044, 0);
      @(posedge clk_i); #1 reg_addr_i = 12'h14C;
      pins(8'h40, 4);
      pins(8'h00, 4);
    end

    phase = "R1/R10 random";
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk_i); #1;
      pin_i = NP'($urandom);
      if ($urandom_range(0, 5) == 0) begin
        int sel;
        sel = $urandom_range(0, 9);
        reg_we_i = 1'b1;
        reg_wdata_i = $urandom;
        if (sel < NP) reg_addr_i = AW'('h074 + 4 * sel);
        else if (sel == 8) reg_addr_i = 12'h04C;
        else reg_addr_i = 12'h048;
      end else begin
        int r;
        r = $urandom_range(0, 5);
        reg_we_i = 1'b0;
        reg_addr_i = (r == 0) ? 12'h14C : (r == 1) ? 12'h05C :
                     (r == 2) ? 12'h060 : 12'h044;
      end
    end
    @(posedge clk_i); #1 reg_we_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule